// File: doc/BRIEF.md
# Dual-Port RAM with Contention Arbiter

A synchronous memory with two identical, independent ports (left and right), each able to read or write any word on any clock. Each port has an enable, a write strobe, an output enable, an address and separate write and read data buses. Reads are registered: the word appears on the read bus one cycle after its address. A write stored in one cycle can be read from the other port in the next cycle.

When both enabled ports point at the same word, an internal arbiter picks a winner and raises a busy flag towards the loser. The winner is the port that reached the address first. When both arrive in the same cycle, left wins. The loser's write is suppressed for as long as its flag is up. A write that is held off completes on its own once the flag drops, if the strobe is still high. A mode strap selects between two roles. In master mode the instance arbitrates and drives its busy outputs. In slave mode the busy outputs stay low and an external arbiter decides, through the busy inputs, which port is blocked.

All delays are whole clock cycles. No port carries back-pressure in the valid/ready sense: the busy flag is a plain status pin, and a blocked requester holds its strobe until the flag clears.

Top module: `dual_port_ram_arb`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits (4096 x 16 by default). A cycle with enable=1 and write strobe=1 on a port that is not blocked stores that port's write data at its address. A cycle with enable=1 and write strobe=0 makes the addressed word appear on that port's read bus after the next rising edge.
- R2: The read bus shows the word, and the drive flag is 1, only in the cycle after a cycle in which enable=1, output enable=1 and write strobe=0. Otherwise the read bus is all zeros and the drive flag is 0. After reset both are 0.
- R3: In master mode, a port's busy output is 1 only while both enables are 1 and both addresses are equal. In that situation exactly one of the two busy outputs is 1.
- R4: Busy drops in the same cycle that the addresses stop matching or either enable goes to 0.
- R5: If one port was already enabled at an address in the previous cycle and the other port moves onto it, the port that was already there wins and the newcomer gets busy. This holds in both directions.
- R6: If both ports start matching in the same cycle, left wins and the right busy output is 1.
- R7: Once a contention has started, the winner does not change until the match ends, even if both ports move together to a new common address.
- R8: A write on a port whose effective busy is 1 does not change the memory, so the word keeps the winner's data.
- R9: A write that was blocked completes in the first cycle in which busy is 0 and the strobe is still 1.
- R10: In slave mode (master_mode=0) both busy outputs are 0 and the internal arbiter has no effect. A port is blocked exactly when its busy input is 1.
- R11: A word written by one port in cycle t is returned by a read on the other port issued in cycle t+1. A read of the same word issued in cycle t returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1: internal arbitration; 0: busy taken from busy inputs |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data, zero when not driven |
| l_rdrive | output | 1 | Left read bus carries valid data |
| l_busy_o | output | 1 | Left lost arbitration (master mode only) |
| l_busy_i | input | 1 | External block for left (slave mode) |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data, zero when not driven |
| r_rdrive | output | 1 | Right read bus carries valid data |
| r_busy_o | output | 1 | Right lost arbitration (master mode only) |
| r_busy_i | input | 1 | External block for right (slave mode) |

## Verification
The assertions take master_mode to be a static strap, changed only while neither port is enabled. The winner-hold check relies on that, because a flip in mid-contention would legitimately change the busy outputs. In slave mode the busy inputs are trusted as given, and the check on blocked writes only claims that the cell keeps its value when the opposite port is not writing that same word. The stimulus changes the strap only between scenarios, with both enables low, and drives every input at the falling edge, so arrival order is always decided by whole cycles.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int NPORT = 2;
  // index 0 is the left port, index 1 the right port
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           master_mode,
  input  logic [NPORT-1:0]               ce,
  input  logic [NPORT-1:0][ADDR_W-1:0]   addr,
  input  logic [NPORT-1:0]               busy_ext,
  output logic [NPORT-1:0]               busy_pin,
  output logic [NPORT-1:0]               busy_eff
);

  logic                         match;
  logic                         match_q;
  logic [NPORT-1:0]             ce_q;
  logic [NPORT-1:0][ADDR_W-1:0] addr_q;
  logic [NPORT-1:0]             stayed;
  logic [NPORT-1:0]             busy_arb;
  side_e                        win_q;
  side_e                        win_now;

  // a port "stayed" when it was enabled at the same address last cycle
  for (genvar g = 0; g < NPORT; g++) begin : g_stay
    assign stayed[g] = ce_q[g] && (addr_q[g] == addr[g]);
  end

  always_comb begin
    match = ce[0] && ce[1] && (addr[0] == addr[1]);
    if (match && !match_q) begin
      // first arrival wins; a simultaneous arrival goes to the left port
      win_now = (stayed[1] && !stayed[0]) ? SIDE_R : SIDE_L;
    end else begin
      win_now = win_q;
    end
    busy_arb[0] = match && (win_now == SIDE_R);
    busy_arb[1] = match && (win_now == SIDE_L);
    busy_pin    = master_mode ? busy_arb : '0;
    busy_eff    = master_mode ? busy_arb : busy_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= '0;
      addr_q  <= '0;
      match_q <= 1'b0;
      win_q   <= SIDE_L;
    end else begin
      ce_q    <= ce;
      addr_q  <= addr;
      match_q <= match;
      win_q   <= match ? win_now : SIDE_L;
    end
  end

  // R3
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_pin[0] && busy_pin[1]));

  // R3
  busy_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|busy_pin) |-> (ce[0] && ce[1] && (addr[0] == addr[1])));

  // R3
  master_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && ce[0] && ce[1] && (addr[0] == addr[1])) |-> ($countones(busy_pin) == 1));

  // R7
  winner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && match && match_q) |-> $stable(busy_pin));

  // R10
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (busy_pin == '0));

endmodule

// File: rtl/dpr_storage.sv
module dpr_storage
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORT-1:0]               wr_req,
  input  logic [NPORT-1:0]               wr_block,
  input  logic [NPORT-1:0]               rd_en,
  input  logic [NPORT-1:0][ADDR_W-1:0]   addr,
  input  logic [NPORT-1:0][DATA_W-1:0]   wdata,
  output logic [NPORT-1:0][DATA_W-1:0]   rdata_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [NPORT-1:0]  wr_en;

  assign wr_en = wr_req & ~wr_block;

  // higher index written first so the left port prevails on a same-word collision
  always_ff @(posedge clk) begin
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (wr_en[p]) mem[addr[p]] <= wdata[p];
    end
  end

  // registered read; a same-edge write is not visible until the next read
  for (genvar g = 0; g < NPORT; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rd_en[g]) rdata_q[g] <= mem[addr[g]];
    end

    // R8
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req[g] && wr_block[g] && !(wr_en[NPORT-1-g] && (addr[NPORT-1-g] == addr[g])))
      |=> (mem[$past(addr[g])] == $past(mem[addr[g]])));
  end

endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic              oe,
  input  logic [DATA_W-1:0] mem_q,
  output logic              wr_req,
  output logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rdrive
);

  logic drive_q;

  assign wr_req = ce && we;
  assign rd_en  = ce && !we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= ce && oe && !we;
  end

  assign rdrive = drive_q;
  assign rdata  = drive_q ? mem_q : '0;

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdrive |-> $past(ce && oe && !we));

endmodule

// File: rtl/dual_port_ram_arb.sv
module dual_port_ram_arb
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rdrive,
  output logic              l_busy_o,
  input  logic              l_busy_i,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rdrive,
  output logic              r_busy_o,
  input  logic              r_busy_i
);

  logic [NPORT-1:0]             ce_v, we_v, oe_v, busy_in_v, busy_pin_v, busy_eff_v;
  logic [NPORT-1:0]             wr_req_v, rd_en_v, rdrive_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic [NPORT-1:0][DATA_W-1:0] wdata_v, mem_q_v, rdata_v;

  assign ce_v      = {r_ce, l_ce};
  assign we_v      = {r_we, l_we};
  assign oe_v      = {r_oe, l_oe};
  assign busy_in_v = {r_busy_i, l_busy_i};
  assign addr_v    = {r_addr, l_addr};
  assign wdata_v   = {r_wdata, l_wdata};

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .ce          (ce_v),
    .addr        (addr_v),
    .busy_ext    (busy_in_v),
    .busy_pin    (busy_pin_v),
    .busy_eff    (busy_eff_v)
  );

  dpr_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req_v),
    .wr_block (busy_eff_v),
    .rd_en    (rd_en_v),
    .addr     (addr_v),
    .wdata    (wdata_v),
    .rdata_q  (mem_q_v)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dpr_port #(.DATA_W(DATA_W)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce     (ce_v[g]),
      .we     (we_v[g]),
      .oe     (oe_v[g]),
      .mem_q  (mem_q_v[g]),
      .wr_req (wr_req_v[g]),
      .rd_en  (rd_en_v[g]),
      .rdata  (rdata_v[g]),
      .rdrive (rdrive_v[g])
    );
  end

  assign l_rdata  = rdata_v[0];
  assign r_rdata  = rdata_v[1];
  assign l_rdrive = rdrive_v[0];
  assign r_rdrive = rdrive_v[1];
  assign l_busy_o = busy_pin_v[0];
  assign r_busy_o = busy_pin_v[1];

endmodule

// File: tb/dual_port_ram_arb_test.sv
`timescale 1ns/1ps
module dual_port_ram_arb_test;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_ce = 0, l_we = 0, l_oe = 0, l_busy_i = 0;
  logic r_ce = 0, r_we = 0, r_oe = 0, r_busy_i = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rdrive, r_rdrive, l_busy_o, r_busy_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_port_ram_arb #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rdrive(l_rdrive), .l_busy_o(l_busy_o), .l_busy_i(l_busy_i),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rdrive(r_rdrive), .r_busy_o(r_busy_o), .r_busy_i(r_busy_i)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_l(logic ce, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d);
    l_ce = ce; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(logic ce, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d);
    r_ce = ce; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    set_l(0, 0, 0, '0, '0); set_r(0, 0, 0, '0, '0);
  endtask

  task automatic wr_l(logic [AW-1:0] a, logic [DW-1:0] d);
    set_l(1, 1, 0, a, d); tick(); set_l(0, 0, 0, '0, '0);
  endtask

  task automatic rd_l(logic [AW-1:0] a, output logic [DW-1:0] v);
    set_l(1, 0, 1, a, '0); tick(); v = l_rdata; set_l(0, 0, 0, '0, '0);
  endtask

  task automatic rd_r(logic [AW-1:0] a, output logic [DW-1:0] v);
    set_r(1, 0, 1, a, '0); tick(); v = r_rdata; set_r(0, 0, 0, '0, '0);
  endtask

  task automatic t_reset();
    chk("R2 reset l_rdata", l_rdata, 0);
    chk("R2 reset l_rdrive", l_rdrive, 0);
    chk("R2 reset r_rdrive", r_rdrive, 0);
    chk("R3 reset busy", {l_busy_o, r_busy_o}, 0);
  endtask

  task automatic t_basic();
    logic [DW-1:0] v;
    set_l(1, 1, 0, 12'd5, 16'hA5A5); set_r(1, 1, 0, 12'd4095, 16'h5A5A);
    #1 chk("R3 no busy on different addr", {l_busy_o, r_busy_o}, 0);
    tick(); idle();
    rd_l(12'd4095, v); chk("R1 left reads right write", v, 16'h5A5A);
    rd_r(12'd5, v);    chk("R1 right reads left write", v, 16'hA5A5);
  endtask

  task automatic t_gate();
    set_l(1, 0, 0, 12'd5, '0); tick();
    chk("R2 oe low rdrive", l_rdrive, 0);
    chk("R2 oe low rdata", l_rdata, 0);
    set_l(1, 1, 1, 12'd6, 16'h0006); tick();
    chk("R2 write cycle rdata", {l_rdrive, l_rdata}, 0);
    set_l(1, 0, 1, 12'd5, '0); tick();
    chk("R2 read driven", {l_rdrive, l_rdata}, {1'b1, 16'hA5A5});
    idle(); tick();
  endtask

  task automatic t_arrival();
    set_r(1, 0, 1, 12'd10, '0); tick();
    set_l(1, 0, 1, 12'd10, '0);
    #1 chk("R5 right first, left busy", {l_busy_o, r_busy_o}, 2'b10);
    tick(); idle(); tick();
    set_l(1, 0, 1, 12'd20, '0); tick();
    set_r(1, 0, 1, 12'd20, '0);
    #1 chk("R5 left first, right busy", {l_busy_o, r_busy_o}, 2'b01);
    tick(); idle(); tick();
  endtask

  task automatic t_tie();
    set_l(1, 0, 1, 12'd30, '0); set_r(1, 0, 1, 12'd30, '0);
    #1 chk("R6 tie goes left", {l_busy_o, r_busy_o}, 2'b01);
    tick(); idle(); tick();
  endtask

  task automatic t_hold_and_end();
    set_r(1, 0, 1, 12'd40, '0); tick();
    set_l(1, 0, 1, 12'd40, '0);
    #1 chk("R5 right holds 40", {l_busy_o, r_busy_o}, 2'b10);
    tick();
    set_l(1, 0, 1, 12'd41, '0); set_r(1, 0, 1, 12'd41, '0);
    #1 chk("R7 winner kept across joint move", {l_busy_o, r_busy_o}, 2'b10);
    tick();
    set_r(1, 0, 1, 12'd42, '0);
    #1 chk("R4 busy clears on mismatch", {l_busy_o, r_busy_o}, 2'b00);
    tick(); idle(); tick();
    set_r(1, 0, 1, 12'd50, '0); tick();
    set_l(1, 0, 1, 12'd50, '0); tick();
    r_ce = 1'b0;
    #1 chk("R4 busy clears on enable low", {l_busy_o, r_busy_o}, 2'b00);
    tick(); idle(); tick();
  endtask

  task automatic t_block();
    logic [DW-1:0] v;
    set_r(1, 1, 0, 12'd60, 16'h1111); tick();
    set_l(1, 1, 0, 12'd60, 16'h2222);
    #1 chk("R8 late writer busy", l_busy_o, 1);
    tick(); tick(); idle(); tick();
    rd_l(12'd60, v); chk("R8 winner data kept", v, 16'h1111);
  endtask

  task automatic t_held_write();
    logic [DW-1:0] v;
    wr_l(12'd70, 16'h0AAA);
    set_r(1, 0, 1, 12'd70, '0); tick();
    set_l(1, 1, 0, 12'd70, 16'h3333);
    #1 chk("R9 writer held", l_busy_o, 1);
    tick();
    chk("R8 blocked write invisible", r_rdata, 16'h0AAA);
    set_r(0, 0, 0, '0, '0);
    #1 chk("R9 busy released", l_busy_o, 0);
    tick(); idle();
    rd_l(12'd70, v); chk("R9 held write landed", v, 16'h3333);
  endtask

  task automatic t_cross();
    logic [DW-1:0] v;
    set_r(1, 1, 0, 12'd80, 16'h4444); set_l(1, 0, 1, 12'd81, '0); tick();
    set_r(0, 0, 0, '0, '0); set_l(1, 0, 1, 12'd80, '0); tick();
    chk("R11 next-cycle read sees write", l_rdata, 16'h4444);
    idle(); tick();
    master_mode = 1'b0;
    wr_l(12'd82, 16'h1234);
    set_r(1, 1, 0, 12'd82, 16'h5678); set_l(1, 0, 1, 12'd82, '0); tick();
    chk("R11 same-cycle read old", l_rdata, 16'h1234);
    set_r(0, 0, 0, '0, '0); tick();
    chk("R11 following read new", l_rdata, 16'h5678);
    idle(); tick();
    rd_l(12'd82, v);
    master_mode = 1'b1;
  endtask

  task automatic t_slave();
    logic [DW-1:0] v;
    master_mode = 1'b0;
    set_r(1, 0, 1, 12'd90, '0); tick();
    set_l(1, 0, 1, 12'd90, '0);
    #1 chk("R10 slave outputs quiet", {l_busy_o, r_busy_o}, 0);
    tick(); idle();
    wr_l(12'd91, 16'h0BBB);
    l_busy_i = 1'b1; wr_l(12'd91, 16'h5555); l_busy_i = 1'b0;
    rd_l(12'd91, v); chk("R10 busy input blocks write", v, 16'h0BBB);
    set_r(1, 0, 1, 12'd92, '0); tick();
    set_l(1, 1, 0, 12'd92, 16'h6666); tick(); idle();
    rd_l(12'd92, v); chk("R10 internal arbiter ignored", v, 16'h6666);
    tick();
    master_mode = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_basic();
    t_gate();
    t_arrival();
    t_tie();
    t_hold_and_end();
    t_block();
    t_held_write();
    t_cross();
    t_slave();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule